// File: doc/BRIEF.md
# Page-Mode DRAM with Held Read Output

This block is a clock-sampled, synthesizable model of the device side of an asynchronous page-mode DRAM. The read data stays driven after the column strobe returns high. A controller opens a row with the row strobe. It then runs any number of column reads and writes in that row. While the data of one read is still on the output, the controller may present the next column address. The held word stays on the output until a later column strobe falling edge selects new data, or until the row strobe rises, or until chip select, output enable or write enable changes level.

Every strobe is sampled on the system clock. A falling or rising edge is found by comparing the present sample of a strobe with its sample from the previous clock. All strobes are active low. The data bus is split into a registered data output and an output-enable flag, and there is a separate data input. The storage array holds `2^(2*ADDR_W)` words. A word is addressed by the row captured at the row strobe falling edge and the column on the address bus at the column strobe falling edge.

The control is a five-state machine:
- `ST_IDLE`: no row is open.
- `ST_ROW_OPEN`: a row is open and the output is off.
- `ST_READ_DRIVE`: read data is driven while the column strobe is low.
- `ST_READ_HOLD`: read data is still driven after the column strobe has returned high.
- `ST_WRITE`: a write cycle, with the output off.

Transitions, checked in this order:
1. A row strobe rise goes from any state to `ST_IDLE`.
2. A row strobe fall goes from `ST_IDLE` to `ST_ROW_OPEN` and captures the row.
3. In an open state, a column strobe fall with chip select low starts a new access:
   - `ST_WRITE` when write enable is low.
   - `ST_READ_DRIVE` when write enable is high and output enable is low.
   - `ST_ROW_OPEN` when write enable and output enable are both high.
4. Otherwise, in an open state, a change of chip select, output enable or write enable goes to `ST_ROW_OPEN`.
5. Otherwise, a column strobe rise goes from `ST_READ_DRIVE` to `ST_READ_HOLD`, and from `ST_WRITE` to `ST_ROW_OPEN`.

Top module: `hpm_dram_model`

## Requirements
- R1: After reset the output-enable flag `dout_en` is low and no row is open.
- R2: A read returns the word at the row captured at the row strobe fall and the column on `addr` at the column strobe fall. `dout` and `dout_en` show it after the first clock edge that samples the column strobe low.
- R3: When the column strobe rises after a read, `dout_en` stays high and `dout` keeps its value.
- R4: While a word is held, a new column address may be presented. The held word is replaced only by the word that the next column strobe fall selects.
- R5: A row strobe rise turns `dout_en` off after the edge that samples it, and closes the row.
- R6: A change in the level of `cs_n`, `oe_n` or `we_n` with no column strobe fall in the same sample turns `dout_en` off.
- R7: A column strobe fall with `we_n` low stores `din` at the open row and the present column. `dout_en` stays low during the write.
- R8: Several reads and writes may run in one row while the row strobe stays low, and no new row address is needed.
- R9: A column strobe fall is ignored when the row strobe is high or when `cs_n` is high. The output stays off and the array is not written.
- R10: A read whose column strobe falls while `oe_n` is high does not drive the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| cs_n | input | 1 | Chip select, active low |
| addr | input | ADDR_W | Multiplexed row and column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, registered |
| dout_en | output | 1 | High while `dout` is driven |

## Verification
The assertions assume that each strobe holds its level for at least one clock. This lets every edge be seen as one change between two samples. They also assume that a strobe or control change and its effect are judged one sample later. The stimulus changes inputs only at the falling clock edge and keeps each level for a whole cycle. It changes control levels in cycles where no column strobe edge is present, except where a test deliberately combines them. Strobes are held inactive through reset, so no false edge follows reset.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_OPEN,
        ST_READ_DRIVE,
        ST_READ_HOLD,
        ST_WRITE
    } acc_state_t;

    localparam int STROBE_N = 5;
    localparam int SB_RAS   = 0;
    localparam int SB_CAS   = 1;
    localparam int SB_OE    = 2;
    localparam int SB_WE    = 3;
    localparam int SB_CS    = 4;

endpackage

// File: rtl/hpm_strobe_edges.sv
module hpm_strobe_edges #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_n;

    for (genvar i = 0; i < N; i++) begin : g_strobe
        always_ff @(posedge clk) begin
            if (!rst_n) prev_n[i] <= 1'b1;
            else        prev_n[i] <= level_n[i];
        end
        assign fall[i] = prev_n[i] & ~level_n[i];
        assign rise[i] = ~prev_n[i] & level_n[i];
    end

endmodule

// File: rtl/hpm_cell_array.sv
module hpm_cell_array #(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int AW    = ROW_W + COL_W;
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [AW-1:0]     idx;

    assign idx     = {row, col};
    assign rd_data = cells[idx];

    always_ff @(posedge clk) begin
        if (wr_en) cells[idx] <= wr_data;
    end

endmodule

// File: rtl/hpm_access_fsm.sv
module hpm_access_fsm
    import hpm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STROBE_N-1:0] level_n,
    input  logic [STROBE_N-1:0] fall,
    input  logic [STROBE_N-1:0] rise,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   row_q,
    output logic                wr_en,
    output logic [DATA_W-1:0]   dout,
    output logic                dout_en
);

    acc_state_t state, nxt;
    logic       load_row;
    logic       rd_take;
    logic       ctrl_chg;
    logic       cas_go;

    assign ctrl_chg = |(fall[SB_CS:SB_OE] | rise[SB_CS:SB_OE]);
    assign cas_go   = fall[SB_CAS] && !level_n[SB_CS];

    always_comb begin
        nxt      = state;
        load_row = 1'b0;
        wr_en    = 1'b0;
        rd_take  = 1'b0;
        if (rise[SB_RAS]) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (fall[SB_RAS]) begin
                        nxt      = ST_ROW_OPEN;
                        load_row = 1'b1;
                    end
                end
                ST_ROW_OPEN, ST_READ_DRIVE, ST_READ_HOLD, ST_WRITE: begin
                    if (cas_go) begin
                        if (!level_n[SB_WE]) begin
                            nxt   = ST_WRITE;
                            wr_en = 1'b1;
                        end else if (!level_n[SB_OE]) begin
                            nxt     = ST_READ_DRIVE;
                            rd_take = 1'b1;
                        end else begin
                            nxt = ST_ROW_OPEN;
                        end
                    end else if (ctrl_chg) begin
                        nxt = ST_ROW_OPEN;
                    end else if (rise[SB_CAS]) begin
                        if (state == ST_READ_DRIVE)  nxt = ST_READ_HOLD;
                        else if (state == ST_WRITE)  nxt = ST_ROW_OPEN;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            dout  <= '0;
        end else begin
            if (load_row) row_q <= addr;
            if (rd_take)  dout  <= rd_data;
        end
    end

    assign dout_en = (state == ST_READ_DRIVE) || (state == ST_READ_HOLD);

    assert_reset_off_R1: assert property (@(posedge clk)
        !rst_n |=> !dout_en);

    assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> (dout_en && dout == $past(rd_data)));

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && !fall[SB_CAS] && !ctrl_chg && !rise[SB_RAS]) |=> (dout_en && $stable(dout)));

    assert_ras_rise_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise[SB_RAS] |=> !dout_en);

    assert_ctrl_change_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_chg && !fall[SB_CAS]) |=> !dout_en);

    assert_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !dout_en);

    assert_closed_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || level_n[SB_CS]) |-> !wr_en);

    assert_oe_high_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fall[SB_CAS] && level_n[SB_OE] && !rise[SB_RAS]) |=> !dout_en);

endmodule

// File: rtl/hpm_dram_model.sv
module hpm_dram_model
    import hpm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic [STROBE_N-1:0] level_n;
    logic [STROBE_N-1:0] fall;
    logic [STROBE_N-1:0] rise;
    logic [ADDR_W-1:0]   row_q;
    logic                wr_en;
    logic [DATA_W-1:0]   rd_data;

    assign level_n = {cs_n, we_n, oe_n, cas_n, ras_n};

    hpm_strobe_edges #(.N(STROBE_N)) u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_n (level_n),
        .fall    (fall),
        .rise    (rise)
    );

    hpm_cell_array #(.ROW_W(ADDR_W), .COL_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
        .clk     (clk),
        .wr_en   (wr_en),
        .row     (row_q),
        .col     (addr),
        .wr_data (din),
        .rd_data (rd_data)
    );

    hpm_access_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_n (level_n),
        .fall    (fall),
        .rise    (rise),
        .addr    (addr),
        .rd_data (rd_data),
        .row_q   (row_q),
        .wr_en   (wr_en),
        .dout    (dout),
        .dout_en (dout_en)
    );

endmodule

// File: tb/hpm_dram_model_tb.sv
`timescale 1ns/1ps
module hpm_dram_model_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, cs_n = 1'b1;
    logic [3:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    int         q_due [$];
    bit         q_en  [$];
    logic [7:0] q_dat [$];
    string      q_tag [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hpm_dram_model u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
        .we_n(we_n), .cs_n(cs_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    // Driver: apply one sample of pins and queue what must be seen one edge later.
    task automatic step(input logic r, input logic c, input logic o, input logic w,
                        input logic s, input logic [3:0] a, input logic [7:0] d,
                        input bit exp_en, input logic [7:0] exp_dat, input string tag);
        ras_n = r; cas_n = c; oe_n = o; we_n = w; cs_n = s; addr = a; din = d;
        q_due.push_back(cyc + 1);
        q_en.push_back(exp_en);
        q_dat.push_back(exp_dat);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: pop items due in this cycle and compare.
    initial begin
        forever begin
            @(negedge clk);
            while (q_due.size() > 0 && q_due[0] == cyc) begin
                automatic bit         e = q_en.pop_front();
                automatic logic [7:0] v = q_dat.pop_front();
                automatic string      t = q_tag.pop_front();
                void'(q_due.pop_front());
                checks++;
                if (dout_en !== e || (e && dout !== v)) begin
                    errors++;
                    $display("FAIL %s: dout_en=%0b dout=%02h, expected dout_en=%0b dout=%02h",
                             t, dout_en, dout, e, v);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): run hung, actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (dout_en !== 1'b0) begin
            errors++;
            $display("FAIL R1: dout_en=%0b, expected 0", dout_en);
        end

        // Writes into row 2, page mode (R7, R8)
        step(0,1,1,1,0, 4'd2, 8'h00, 0, 8'h00, "R7");
        step(0,1,1,0,0, 4'd0, 8'h00, 0, 8'h00, "R7");
        step(0,0,1,0,0, 4'd5, 8'hA5, 0, 8'h00, "R7");
        step(0,1,1,0,0, 4'd6, 8'h00, 0, 8'h00, "R7");
        step(0,0,1,0,0, 4'd6, 8'h3C, 0, 8'h00, "R8");
        step(0,1,1,0,0, 4'd7, 8'h00, 0, 8'h00, "R8");
        step(0,0,1,0,0, 4'd7, 8'h99, 0, 8'h00, "R8");
        step(0,1,1,0,0, 4'd0, 8'h00, 0, 8'h00, "R7");
        step(1,1,1,1,0, 4'd0, 8'h00, 0, 8'h00, "R5");
        // Write row 3 col 5
        step(0,1,1,1,0, 4'd3, 8'h00, 0, 8'h00, "R2");
        step(0,1,1,0,0, 4'd0, 8'h00, 0, 8'h00, "R7");
        step(0,0,1,0,0, 4'd5, 8'h5A, 0, 8'h00, "R7");
        step(0,1,1,0,0, 4'd0, 8'h00, 0, 8'h00, "R7");
        step(1,1,1,1,0, 4'd0, 8'h00, 0, 8'h00, "R5");

        // Reads in row 2 with overlap (R2, R3, R4, R8)
        step(0,1,1,1,0, 4'd2, 8'h00, 0, 8'h00, "R2");
        step(0,1,0,1,0, 4'd0, 8'h00, 0, 8'h00, "R6");
        step(0,0,0,1,0, 4'd5, 8'h00, 1, 8'hA5, "R2");
        step(0,1,0,1,0, 4'd6, 8'h00, 1, 8'hA5, "R3");
        step(0,1,0,1,0, 4'd6, 8'h00, 1, 8'hA5, "R3");
        step(0,0,0,1,0, 4'd6, 8'h00, 1, 8'h3C, "R4");
        step(0,1,0,1,0, 4'd7, 8'h00, 1, 8'h3C, "R4");
        step(0,0,0,1,0, 4'd7, 8'h00, 1, 8'h99, "R8");
        step(0,1,0,1,0, 4'd0, 8'h00, 1, 8'h99, "R3");
        step(1,1,0,1,0, 4'd0, 8'h00, 0, 8'h00, "R5");

        // Column strobe with row closed: no read, no write (R9, R5)
        step(1,0,0,1,0, 4'd5, 8'h00, 0, 8'h00, "R9");
        step(1,1,0,1,0, 4'd5, 8'h00, 0, 8'h00, "R5");
        step(1,1,0,0,0, 4'd5, 8'h00, 0, 8'h00, "R9");
        step(1,0,0,0,0, 4'd5, 8'hFF, 0, 8'h00, "R9");
        step(1,1,0,0,0, 4'd5, 8'h00, 0, 8'h00, "R9");
        step(1,1,0,1,0, 4'd5, 8'h00, 0, 8'h00, "R9");

        // Row 3 read checks row capture (R2)
        step(0,1,0,1,0, 4'd3, 8'h00, 0, 8'h00, "R2");
        step(0,0,0,1,0, 4'd5, 8'h00, 1, 8'h5A, "R2");
        step(0,1,0,1,0, 4'd5, 8'h00, 1, 8'h5A, "R3");
        step(1,1,0,1,0, 4'd0, 8'h00, 0, 8'h00, "R5");

        // Row 2 again: ignored write left A5 (R9), then control changes (R6)
        step(0,1,0,1,0, 4'd2, 8'h00, 0, 8'h00, "R2");
        step(0,0,0,1,0, 4'd5, 8'h00, 1, 8'hA5, "R9");
        step(0,1,0,1,0, 4'd5, 8'h00, 1, 8'hA5, "R3");
        step(0,1,1,1,0, 4'd5, 8'h00, 0, 8'h00, "R6");
        step(0,1,0,1,0, 4'd5, 8'h00, 0, 8'h00, "R6");
        step(0,0,0,1,0, 4'd6, 8'h00, 1, 8'h3C, "R4");
        step(0,1,0,1,0, 4'd6, 8'h00, 1, 8'h3C, "R3");
        step(0,1,0,1,1, 4'd6, 8'h00, 0, 8'h00, "R6");
        step(0,1,0,1,0, 4'd6, 8'h00, 0, 8'h00, "R6");
        step(0,0,0,1,0, 4'd7, 8'h00, 1, 8'h99, "R8");
        step(0,1,0,1,0, 4'd7, 8'h00, 1, 8'h99, "R3");
        step(0,1,0,0,0, 4'd7, 8'h00, 0, 8'h00, "R6");
        step(0,1,0,1,0, 4'd7, 8'h00, 0, 8'h00, "R6");

        // Read with output enable high (R10)
        step(0,1,1,1,0, 4'd5, 8'h00, 0, 8'h00, "R10");
        step(0,0,1,1,0, 4'd5, 8'h00, 0, 8'h00, "R10");
        step(0,1,1,1,0, 4'd5, 8'h00, 0, 8'h00, "R10");

        // Column strobe while deselected (R9)
        step(0,1,0,1,1, 4'd5, 8'h00, 0, 8'h00, "R9");
        step(0,0,0,1,1, 4'd5, 8'h00, 0, 8'h00, "R9");
        step(0,1,0,1,1, 4'd5, 8'h00, 0, 8'h00, "R9");
        step(1,1,1,1,1, 4'd0, 8'h00, 0, 8'h00, "R5");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule